// File: doc/BRIEF.md
# Write-Masked GPIO Controller with Interrupts

This block controls 32 general-purpose pins from a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. Each control function is stored as a pair of 16-bit words. One word covers pins 0 to 15 and the other covers pins 16 to 31. Every write to a control word carries per-bit write enables in its upper half. Software can therefore change one pin's output, direction or interrupt setting in a single write, with no read-modify-write.

Pin inputs pass through a two-flop synchronizer. The synchronized levels can be read back and also feed the interrupt logic. Each pin is set to detect either a level or an edge, and its polarity picks active-high or rising versus active-low or falling. An edge sets a sticky status bit, which software clears by writing to an end-of-interrupt word. A level condition follows the pin and is not latched. A single interrupt output is raised when any enabled, unmasked pin is pending.

Top module: `wm_gpio`

## Requirements
- R1: After reset every stored register is 0. `pin_oe` and `pin_out` are 0 and `irq` is 0.
- R2: For a write to a control word, bit k of the stored value (k in 0..15) takes `bus_wdata[k]` only when `bus_wdata[16+k]` is 1. Otherwise it keeps its value. A read of a control word returns the stored 16 bits in 15:0, and bits 31:16 read as 0.
- R3: Pin n is held in the low word (offsets 0x00 output data, 0x08 direction, 0x10 enable, 0x18 mask, 0x20 type, 0x28 polarity) when n/16 is 0. It is held in the word 4 bytes above when n/16 is 1, at bit n mod 16. The output data bit drives `pin_out[n]`. A direction bit of 1 drives `pin_oe[n]` high, making the pin an output.
- R4: A read at 0x70 returns the levels of all 32 pins, with pin n in bit n. A pin change is visible in this read two clock edges after it is applied.
- R5: A read at 0x78 returns the constant 0x0101157C.
- R6: With a type bit of 0, the pin is level-triggered. It is pending while its level equals its polarity bit (1 for high, 0 for low) and stops being pending as soon as the level changes.
- R7: With a type bit of 1, the pin is edge-triggered. Polarity 1 selects a rising edge and polarity 0 selects a falling edge. A detected edge on an enabled pin sets a sticky bit. Writing 1 to the pin's bit, with its enable bit set, at 0x60 (pins 0-15) or 0x64 (pins 16-31) clears the sticky bit. An edge of the opposite direction never sets it.
- R8: `irq` is the OR over all pins of pending status AND enable bit 1 AND mask bit 0. A mask bit of 1 or an enable bit of 0 keeps that pin from raising `irq`.
- R9: Reads of unmapped offsets, including the write-only words at 0x60 and 0x64, return 0. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data: enables in 31:16, values in 15:0 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Pin levels from the pads (asynchronous) |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enables to the pads (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
The embedded properties assume that bus inputs are stable around the rising clock edge. They also assume that at most one write happens per cycle, addressed by a full byte offset. The bench drives every bus signal and pin on the falling edge and holds each write for exactly one rising edge, so these assumptions hold. Pin changes are applied only while the bus is idle. The bench then waits out the two-flop synchronizer, plus the edge flop and the sticky register, before it samples. This keeps every expected value free of timing ambiguity at the synchronizer.

// File: rtl/wm_gpio.sv
module wm_gpio #(
  parameter int          ADDR_W  = 8,
  parameter int          NPIN    = 32,
  parameter logic [31:0] VERSION = 32'h0101_157C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq
);
  localparam int HW = NPIN / 2;

  localparam logic [ADDR_W-1:0] A_DOUT_L = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_DOUT_H = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_DIR_L  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_DIR_H  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_IEN_L  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_IEN_H  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_MSK_L  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_MSK_H  = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_TYP_L  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_TYP_H  = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] A_POL_L  = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] A_POL_H  = ADDR_W'('h2C);
  localparam logic [ADDR_W-1:0] A_EOI_L  = ADDR_W'('h60);
  localparam logic [ADDR_W-1:0] A_EOI_H  = ADDR_W'('h64);
  localparam logic [ADDR_W-1:0] A_LVL    = ADDR_W'('h70);
  localparam logic [ADDR_W-1:0] A_VER    = ADDR_W'('h78);

  logic [NPIN-1:0] dout_q, dir_q, ien_q, msk_q, typ_q, pol_q, sts_q;
  logic [NPIN-1:0] sy1_q, sy2_q, sy3_q;
  logic [NPIN-1:0] eoi_clr, edge_hit, lvl_hit, pend;
  logic            mapped;

  function automatic logic [HW-1:0] mw(input logic [HW-1:0] old, input logic [31:0] wd);
    return (old & ~wd[16 +: HW]) | (wd[HW-1:0] & wd[16 +: HW]);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0; dir_q <= '0; ien_q <= '0;
      msk_q  <= '0; typ_q <= '0; pol_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_DOUT_L: dout_q[HW-1:0]    <= mw(dout_q[HW-1:0], bus_wdata);
        A_DOUT_H: dout_q[NPIN-1:HW] <= mw(dout_q[NPIN-1:HW], bus_wdata);
        A_DIR_L:  dir_q[HW-1:0]     <= mw(dir_q[HW-1:0], bus_wdata);
        A_DIR_H:  dir_q[NPIN-1:HW]  <= mw(dir_q[NPIN-1:HW], bus_wdata);
        A_IEN_L:  ien_q[HW-1:0]     <= mw(ien_q[HW-1:0], bus_wdata);
        A_IEN_H:  ien_q[NPIN-1:HW]  <= mw(ien_q[NPIN-1:HW], bus_wdata);
        A_MSK_L:  msk_q[HW-1:0]     <= mw(msk_q[HW-1:0], bus_wdata);
        A_MSK_H:  msk_q[NPIN-1:HW]  <= mw(msk_q[NPIN-1:HW], bus_wdata);
        A_TYP_L:  typ_q[HW-1:0]     <= mw(typ_q[HW-1:0], bus_wdata);
        A_TYP_H:  typ_q[NPIN-1:HW]  <= mw(typ_q[NPIN-1:HW], bus_wdata);
        A_POL_L:  pol_q[HW-1:0]     <= mw(pol_q[HW-1:0], bus_wdata);
        A_POL_H:  pol_q[NPIN-1:HW]  <= mw(pol_q[NPIN-1:HW], bus_wdata);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= '0; sy2_q <= '0; sy3_q <= '0; sts_q <= '0;
    end else begin
      sy1_q <= pin_in;
      sy2_q <= sy1_q;
      sy3_q <= sy2_q;
      sts_q <= (sts_q & ~eoi_clr) | edge_hit;
    end
  end

  always_comb begin
    eoi_clr = '0;
    if (bus_we && bus_addr == A_EOI_L) eoi_clr[HW-1:0]    = bus_wdata[16 +: HW] & bus_wdata[HW-1:0];
    if (bus_we && bus_addr == A_EOI_H) eoi_clr[NPIN-1:HW] = bus_wdata[16 +: HW] & bus_wdata[HW-1:0];
  end

  assign edge_hit = typ_q & ien_q & ((pol_q & sy2_q & ~sy3_q) | (~pol_q & ~sy2_q & sy3_q));
  assign lvl_hit  = ~typ_q & ~(sy2_q ^ pol_q);
  assign pend     = (sts_q | lvl_hit) & ien_q & ~msk_q;
  assign irq      = |pend;
  assign pin_out  = dout_q;
  assign pin_oe   = dir_q;

  always_comb begin
    bus_rdata = '0;
    mapped    = 1'b1;
    case (bus_addr)
      A_DOUT_L: bus_rdata[HW-1:0] = dout_q[HW-1:0];
      A_DOUT_H: bus_rdata[HW-1:0] = dout_q[NPIN-1:HW];
      A_DIR_L:  bus_rdata[HW-1:0] = dir_q[HW-1:0];
      A_DIR_H:  bus_rdata[HW-1:0] = dir_q[NPIN-1:HW];
      A_IEN_L:  bus_rdata[HW-1:0] = ien_q[HW-1:0];
      A_IEN_H:  bus_rdata[HW-1:0] = ien_q[NPIN-1:HW];
      A_MSK_L:  bus_rdata[HW-1:0] = msk_q[HW-1:0];
      A_MSK_H:  bus_rdata[HW-1:0] = msk_q[NPIN-1:HW];
      A_TYP_L:  bus_rdata[HW-1:0] = typ_q[HW-1:0];
      A_TYP_H:  bus_rdata[HW-1:0] = typ_q[NPIN-1:HW];
      A_POL_L:  bus_rdata[HW-1:0] = pol_q[HW-1:0];
      A_POL_H:  bus_rdata[HW-1:0] = pol_q[NPIN-1:HW];
      A_EOI_L, A_EOI_H: ;
      A_LVL:    bus_rdata[NPIN-1:0] = sy2_q;
      A_VER:    bus_rdata = VERSION;
      default:  mapped = 1'b0;
    endcase
  end

  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq));

  // R2
  dir_lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DIR_L && bus_wdata[31:16] == '0) |=> $stable(pin_oe));

  // R7
  sticky_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_q & ~$past(sts_q))) |-> (|$past(typ_q & ien_q)));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(ien_q & ~msk_q)));

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !mapped) |=> ($stable(dout_q) && $stable(dir_q) && $stable(ien_q) &&
                             $stable(msk_q) && $stable(typ_q) && $stable(pol_q)));
endmodule

// File: tb/wm_gpio_bench.sv
module wm_gpio_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  wm_gpio u_wm_gpio (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd("R1 ien_hi", 8'h14, 32'h0);
  endtask

  task automatic t_masked_write;
    wr(8'h00, 32'h00FF_00AA);
    check("R2 low-byte write", pin_out, 32'h0000_00AA);
    wr(8'h00, 32'h0001_FFFF);
    rd("R2 single bit enable", 8'h00, 32'h0000_00AB);
    wr(8'h00, 32'h0000_FFFF);
    rd("R2 no enables", 8'h00, 32'h0000_00AB);
    wr(8'h18, 32'hFFFF_1234);
    rd("R2 upper reads zero", 8'h18, 32'h0000_1234);
    wr(8'h18, 32'hFFFF_0000);
  endtask

  task automatic t_split;
    wr(8'h04, 32'h8000_8000);
    check("R3 high data pin31", pin_out, 32'h8000_00AB);
    wr(8'h0C, 32'h8000_8000);
    check("R3 high dir pin31", pin_oe, 32'h8000_0000);
    wr(8'h08, 32'h0001_0001);
    check("R3 low dir pin0", pin_oe, 32'h8000_0001);
    wr(8'h0C, 32'h8000_0000);
    check("R3 dir clear pin31", pin_oe, 32'h0000_0001);
  endtask

  task automatic t_readback;
    pin_in = 32'hDEAD_BEEF;
    @(negedge clk);
    rd("R4 one edge not yet", 8'h70, 32'h0);
    @(negedge clk);
    rd("R4 two edges", 8'h70, 32'hDEAD_BEEF);
    pin_in = 32'h0;
    settle(3);
    rd("R4 back to zero", 8'h70, 32'h0);
  endtask

  task automatic t_version;
    rd("R5 version", 8'h78, 32'h0101_157C);
  endtask

  task automatic t_unmapped;
    wr(8'h40, 32'hFFFF_FFFF);
    rd("R9 unmapped read", 8'h40, 32'h0);
    rd("R9 data kept", 8'h00, 32'h0000_00AB);
    rd("R9 dir kept", 8'h08, 32'h0000_0001);
    rd("R9 eoi reads zero", 8'h60, 32'h0);
  endtask

  task automatic t_level;
    wr(8'h2C, 32'h0010_0010);
    wr(8'h14, 32'h0010_0010);
    settle(3);
    check("R6 low pin no irq", {31'b0, irq}, 32'h0);
    pin_in[20] = 1'b1; settle(3);
    check("R6 high level irq", {31'b0, irq}, 32'h1);
    pin_in[20] = 1'b0; settle(3);
    check("R6 not latched", {31'b0, irq}, 32'h0);
    pin_in[20] = 1'b1; settle(3);
    wr(8'h1C, 32'h0010_0010);
    check("R8 masked", {31'b0, irq}, 32'h0);
    wr(8'h1C, 32'h0010_0000);
    check("R8 unmasked", {31'b0, irq}, 32'h1);
    wr(8'h14, 32'h0010_0000);
    check("R8 enable off", {31'b0, irq}, 32'h0);
    pin_in[20] = 1'b0; settle(3);
  endtask

  task automatic t_edge;
    wr(8'h20, 32'h0008_0008);
    wr(8'h28, 32'h0008_0008);
    wr(8'h10, 32'h0008_0008);
    settle(3);
    check("R7 idle", {31'b0, irq}, 32'h0);
    pin_in[3] = 1'b1; settle(4);
    check("R7 rising edge", {31'b0, irq}, 32'h1);
    pin_in[3] = 1'b0; settle(4);
    check("R7 sticky", {31'b0, irq}, 32'h1);
    wr(8'h60, 32'h0000_0008);
    check("R7 eoi without enable", {31'b0, irq}, 32'h1);
    wr(8'h64, 32'h0008_0008);
    check("R7 eoi wrong half", {31'b0, irq}, 32'h1);
    wr(8'h60, 32'h0008_0008);
    check("R7 eoi clears", {31'b0, irq}, 32'h0);
    wr(8'h28, 32'h0008_0000);
    pin_in[3] = 1'b1; settle(4);
    check("R7 rise ignored when falling", {31'b0, irq}, 32'h0);
    pin_in[3] = 1'b0; settle(4);
    check("R7 falling edge", {31'b0, irq}, 32'h1);
    wr(8'h60, 32'h0008_0008);
    check("R7 falling cleared", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    t_reset;
    t_masked_write;
    t_split;
    t_readback;
    t_version;
    t_unmapped;
    t_level;
    t_edge;
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule